// File: doc/BRIEF.md
# Macro Sequencer Arithmetic and Bitfield Unit

This unit is the execution stage of a small macro sequencer. Each cycle the sequencer may present one 32-bit instruction word with the values of its two source registers. The unit decodes the operation form from the low bits of the word and computes a 32-bit result one clock later. It covers register-to-register arithmetic and logic, add-immediate, three bitfield forms and the address calculation for a register read. The carry flag used by chained arithmetic is held inside the unit.

The sequencer uses the registered outputs to decide what to do next. When the read-request flag is set, the result is an address to look up, and the sequencer fetches the value itself. When the invalid flag is set, the result is zero and no state has changed. The unit does not sequence, fetch or emit anything.

Top module: `macro_alu`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `carry`, `carry_we`, `rd_req` and `invalid` are all 0.
- R2: An operation presented with `in_valid` high at one rising edge appears on `result` and the flags after that edge and before the next one. `out_valid` is high for exactly that cycle. `carry_we`, `rd_req` and `invalid` are 0 whenever `out_valid` is 0.
- R3: Form code `instr[2:0]` = 0 selects a register-register operation with sub-code `instr[21:17]`. Sub-codes 8, 9, 10, 11 and 12 give A XOR B, A OR B, A AND B, A AND NOT B and NOT (A AND B). These logic sub-codes leave `carry` unchanged with `carry_we` = 0.
- R4: Sub-code 0 gives A+B and sub-code 1 gives A+B+carry, both taken modulo 2^32. Each sets `carry` to bit 32 of the exact sum and raises `carry_we`.
- R5: Sub-code 2 gives A−B and sub-code 3 gives A−B−(1−carry). Each sets `carry` to 1 exactly when no borrow occurs, meaning the subtrahend does not exceed A, and raises `carry_we`.
- R6: Form 1 returns A plus the sign-extended 18-bit immediate `instr[31:14]`, modulo 2^32, without touching `carry`.
- R7: Form 2 (bitfield replace) uses source position `instr[21:17]`, size `instr[26:22]`, destination position `instr[31:27]` and mask M = 2^size − 1. It returns A with bits M<<dst cleared and ((B>>src)&M)<<dst inserted. A size of 0 returns A unchanged.
- R8: Form 3 returns ((B >> A[4:0]) & M) << dst, using logical shifts. Only the low five bits of A give the shift amount.
- R9: Form 4 returns ((B >> src) & M) << A[4:0].
- R10: Form 5 returns A plus the sign-extended immediate as an address and raises `rd_req`. It does not write `carry`.
- R11: Form codes 6 and 7, and register-register sub-codes 4 to 7 and 13 to 31, raise `invalid`. In that case `result` is 0, `rd_req` and `carry_we` are 0, and `carry` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | DATA_W | Value of source register A |
| src_b | input | DATA_W | Value of source register B |
| out_valid | output | 1 | Registered result is valid this cycle |
| result | output | DATA_W | Registered result or read address |
| carry | output | 1 | Current carry flag |
| carry_we | output | 1 | The carry flag was written by this result |
| rd_req | output | 1 | Result is an address to read |
| invalid | output | 1 | The operation code was not recognised |

## Verification
The embedded assertions watch the cycle-by-cycle invariants on every cycle. These are: `out_valid` follows `in_valid` one edge later, the flags appear only with a valid result and never two at once, the carry holds whenever it is not written, and an invalid code yields a zero result. Only the bench's directed scenarios can show that the arithmetic values are right. That covers carry and no-borrow propagation across chained add-with-carry and subtract-with-borrow operations, sign extension of negative immediates, and the field placement of the three bitfield forms, including a zero-size field and a shift amount taken from the low bits of A.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;

  localparam int INSTR_W = 32;
  localparam int FORM_W  = 3;
  localparam int SUBOP_W = 5;
  localparam int POS_W   = 5;
  localparam int IMM_W   = 18;
  localparam int IMM_LSB = 14;
  localparam int SUB_LSB = 17;
  localparam int SIZ_LSB = 22;
  localparam int DST_LSB = 27;

  typedef enum logic [FORM_W-1:0] {
    FM_REGOP   = 3'd0,
    FM_ADDI    = 3'd1,
    FM_BF_REPL = 3'd2,
    FM_BF_SHRA = 3'd3,
    FM_BF_SHLA = 3'd4,
    FM_RDADDR  = 3'd5,
    FM_RSV6    = 3'd6,
    FM_RSV7    = 3'd7
  } form_e;

  typedef enum logic [SUBOP_W-1:0] {
    RO_ADD  = 5'd0,
    RO_ADC  = 5'd1,
    RO_SUB  = 5'd2,
    RO_SBB  = 5'd3,
    RO_XOR  = 5'd8,
    RO_OR   = 5'd9,
    RO_AND  = 5'd10,
    RO_ANDN = 5'd11,
    RO_NAND = 5'd12
  } regop_e;

  typedef struct packed {
    form_e              form;
    logic [SUBOP_W-1:0] subop;
    logic [POS_W-1:0]   src_pos;
    logic [POS_W-1:0]   size;
    logic [POS_W-1:0]   dst_pos;
    logic [IMM_W-1:0]   imm;
  } dec_t;

  function automatic dec_t decode(input logic [INSTR_W-1:0] w);
    dec_t d;
    d.form    = form_e'(w[FORM_W-1:0]);
    d.subop   = w[SUB_LSB +: SUBOP_W];
    d.src_pos = w[SUB_LSB +: POS_W];
    d.size    = w[SIZ_LSB +: POS_W];
    d.dst_pos = w[DST_LSB +: POS_W];
    d.imm     = w[IMM_LSB +: IMM_W];
    return d;
  endfunction

endpackage

// File: rtl/macro_alu_regop.sv
module macro_alu_regop
  import macro_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [SUBOP_W-1:0] subop,
  input  logic [DATA_W-1:0]  a,
  input  logic [DATA_W-1:0]  b,
  input  logic               cin,
  output logic [DATA_W-1:0]  res,
  output logic               cout,
  output logic               carry_wr,
  output logic               bad
);

  localparam int SUM_W = DATA_W + 1;

  logic [SUM_W-1:0] a_x, b_x, nb_x, cin_x, sum;

  assign a_x   = {1'b0, a};
  assign b_x   = {1'b0, b};
  assign nb_x  = {1'b0, ~b};
  assign cin_x = {{DATA_W{1'b0}}, cin};

  always_comb begin
    sum      = '0;
    res      = '0;
    cout     = 1'b0;
    carry_wr = 1'b0;
    bad      = 1'b0;
    case (subop)
      RO_ADD:  sum = a_x + b_x;
      RO_ADC:  sum = a_x + b_x + cin_x;
      RO_SUB:  sum = a_x + nb_x + SUM_W'(1);
      RO_SBB:  sum = a_x + nb_x + cin_x;
      default: sum = '0;
    endcase
    case (subop)
      RO_ADD, RO_ADC, RO_SUB, RO_SBB: begin
        res      = sum[DATA_W-1:0];
        cout     = sum[DATA_W];
        carry_wr = 1'b1;
      end
      RO_XOR:  res = a ^ b;
      RO_OR:   res = a | b;
      RO_AND:  res = a & b;
      RO_ANDN: res = a & ~b;
      RO_NAND: res = ~(a & b);
      default: bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/macro_alu_bitfield.sv
module macro_alu_bitfield
  import macro_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  form_e             form,
  input  logic [POS_W-1:0]  src_pos,
  input  logic [POS_W-1:0]  size,
  input  logic [POS_W-1:0]  dst_pos,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);

  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] mask, fld_imm, fld_reg;
  logic [SH_W-1:0]   a_sh;

  assign a_sh    = a[SH_W-1:0];
  assign mask    = (DATA_W'(1) << size) - DATA_W'(1);
  assign fld_imm = (b >> src_pos) & mask;
  assign fld_reg = (b >> a_sh) & mask;

  always_comb begin
    case (form)
      FM_BF_REPL: res = (a & ~(mask << dst_pos)) | (fld_imm << dst_pos);
      FM_BF_SHRA: res = fld_reg << dst_pos;
      FM_BF_SHLA: res = fld_imm << a_sh;
      default:    res = '0;
    endcase
  end

endmodule

// File: rtl/macro_alu_addimm.sv
module macro_alu_addimm
  import macro_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] sum
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx;

  assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign sum    = a + imm_sx;

endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import macro_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              carry_we,
  output logic              rd_req,
  output logic              invalid
);

  dec_t dec;
  assign dec = decode(instr);

  logic [DATA_W-1:0] ro_res, bf_res, imm_sum;
  logic              ro_cout, ro_cwr, ro_bad;

  macro_alu_regop #(.DATA_W(DATA_W)) u_regop (
    .subop    (dec.subop),
    .a        (src_a),
    .b        (src_b),
    .cin      (carry),
    .res      (ro_res),
    .cout     (ro_cout),
    .carry_wr (ro_cwr),
    .bad      (ro_bad)
  );

  macro_alu_bitfield #(.DATA_W(DATA_W)) u_bitfield (
    .form    (dec.form),
    .src_pos (dec.src_pos),
    .size    (dec.size),
    .dst_pos (dec.dst_pos),
    .a       (src_a),
    .b       (src_b),
    .res     (bf_res)
  );

  macro_alu_addimm #(.DATA_W(DATA_W)) u_addimm (
    .a   (src_a),
    .imm (dec.imm),
    .sum (imm_sum)
  );

  logic [DATA_W-1:0] n_res;
  logic              n_cwe, n_cout, n_rd, n_inv;

  always_comb begin
    n_res  = '0;
    n_cwe  = 1'b0;
    n_cout = 1'b0;
    n_rd   = 1'b0;
    n_inv  = 1'b0;
    case (dec.form)
      FM_REGOP: begin
        n_inv  = ro_bad;
        n_res  = ro_bad ? '0 : ro_res;
        n_cwe  = ro_cwr;
        n_cout = ro_cout;
      end
      FM_ADDI:                          n_res = imm_sum;
      FM_BF_REPL, FM_BF_SHRA, FM_BF_SHLA: n_res = bf_res;
      FM_RDADDR: begin
        n_res = imm_sum;
        n_rd  = 1'b1;
      end
      default: n_inv = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry     <= 1'b0;
      carry_we  <= 1'b0;
      rd_req    <= 1'b0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      carry_we  <= in_valid & n_cwe;
      rd_req    <= in_valid & n_rd;
      invalid   <= in_valid & n_inv;
      if (in_valid) begin
        result <= n_res;
        if (n_cwe) carry <= n_cout;
      end
    end
  end

  // R2: one-edge latency from request to valid result
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst)) |-> (out_valid == $past(in_valid)));

  // R2: side flags only accompany a valid result
  assert_flags_qualified_R2: assert property (@(posedge clk) disable iff (rst)
    (carry_we || rd_req || invalid) |-> out_valid);

  // R3, R6, R11: carry moves only together with a carry write
  assert_carry_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !carry_we |-> $stable(carry));

  // R10: a read request never comes with a carry write or an invalid code
  assert_read_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({carry_we, rd_req, invalid}));

  // R11: an invalid operation yields a zero result
  assert_invalid_zero_R11: assert property (@(posedge clk) disable iff (rst)
    invalid |-> (result == '0));

endmodule

// File: tb/macro_alu_tb_top.sv
module macro_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        out_valid, carry, carry_we, rd_req, invalid;
  logic [31:0] result;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  bit mc       = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  macro_alu dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
    .carry(carry), .carry_we(carry_we), .rd_req(rd_req), .invalid(invalid)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_rr(input logic [4:0] sub);
    return {10'd0, sub, 14'd0, 3'd0};
  endfunction
  function automatic logic [31:0] mk_imm(input logic [2:0] form, input logic [17:0] imm);
    return {imm, 11'd0, form};
  endfunction
  function automatic logic [31:0] mk_bf(input logic [2:0] form, input logic [4:0] src,
                                        input logic [4:0] size, input logic [4:0] dst);
    return {dst, size, src, 14'd0, form};
  endfunction

  // Reference computed from the requirement text
  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input bit cin, output logic [31:0] r, output bit co, output bit cwe,
                       output bit rd, output bit inv);
    logic [32:0] wide;
    logic [31:0] m, sx;
    logic [4:0]  sub, sp, sz, dp;
    sub = ins[21:17]; sp = ins[21:17]; sz = ins[26:22]; dp = ins[31:27];
    m   = (32'd1 << sz) - 32'd1;
    sx  = {{14{ins[31]}}, ins[31:14]};
    r = '0; co = cin; cwe = 0; rd = 0; inv = 0;
    case (ins[2:0])
      3'd0: case (sub)
        5'd0: begin wide = {1'b0, a} + {1'b0, b}; r = wide[31:0]; co = wide[32]; cwe = 1; end
        5'd1: begin wide = {1'b0, a} + {1'b0, b} + 33'(cin); r = wide[31:0]; co = wide[32]; cwe = 1; end
        5'd2: begin r = a - b; co = (a >= b); cwe = 1; end
        5'd3: begin
          r = a - b - 32'(!cin);
          co = ({1'b0, a} >= ({1'b0, b} + 33'(!cin))); cwe = 1;
        end
        5'd8:  r = a ^ b;
        5'd9:  r = a | b;
        5'd10: r = a & b;
        5'd11: r = a & ~b;
        5'd12: r = ~(a & b);
        default: inv = 1;
      endcase
      3'd1: r = a + sx;
      3'd2: r = (a & ~(m << dp)) | (((b >> sp) & m) << dp);
      3'd3: r = ((b >> a[4:0]) & m) << dp;
      3'd4: r = ((b >> sp) & m) << a[4:0];
      3'd5: begin r = a + sx; rd = 1; end
      default: inv = 1;
    endcase
  endtask

  task automatic run_op(input string tag, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    bit ec, ew, erd, einv;
    @(negedge clk);
    instr = ins; src_a = a; src_b = b; in_valid = 1'b1;
    model(ins, a, b, mc, er, ec, ew, erd, einv);
    @(negedge clk);
    in_valid = 1'b0;
    if (ew) mc = ec;
    chk(tag, "out_valid", 32'(out_valid), 32'd1);
    chk(tag, "result",    result, er);
    chk(tag, "carry",     32'(carry), 32'(mc));
    chk(tag, "carry_we",  32'(carry_we), 32'(ew));
    chk(tag, "rd_req",    32'(rd_req), 32'(erd));
    chk(tag, "invalid",   32'(invalid), 32'(einv));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "flags", {28'd0, carry, carry_we, rd_req, invalid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "flags after release", {27'd0, out_valid, carry, carry_we, rd_req, invalid}, 0);
    mc = 0;
  endtask

  task automatic t_add_carry;
    run_op("R4", mk_rr(5'd0), 32'hFFFF_FFFF, 32'h0000_0001);
    run_op("R4", mk_rr(5'd1), 32'h0000_0001, 32'h0000_0001);
    run_op("R4", mk_rr(5'd1), 32'h8000_0000, 32'h8000_0000);
    run_op("R4", mk_rr(5'd0), 32'h1234_0000, 32'h0000_5678);
  endtask

  task automatic t_sub_borrow;
    run_op("R5", mk_rr(5'd2), 32'd5, 32'd3);
    run_op("R5", mk_rr(5'd2), 32'd3, 32'd5);
    run_op("R5", mk_rr(5'd3), 32'd10, 32'd3);
    run_op("R5", mk_rr(5'd3), 32'd10, 32'd3);
    run_op("R5", mk_rr(5'd3), 32'd0, 32'd0);
  endtask

  task automatic t_logic;
    run_op("R3", mk_rr(5'd0), 32'hFFFF_FFFF, 32'd1);
    for (int s = 8; s <= 12; s++)
      run_op("R3", mk_rr(5'(s)), 32'hF0F0_CC33, 32'h0FF0_AA55);
  endtask

  task automatic t_addi;
    run_op("R6", mk_imm(3'd1, 18'h3FFF9), 32'd5, 32'h0);
    run_op("R6", mk_imm(3'd1, 18'h1FFFF), 32'h1000_0000, 32'hDEAD_BEEF);
  endtask

  task automatic t_bf_replace;
    run_op("R7", mk_bf(3'd2, 5'd4, 5'd8, 5'd12), 32'hFFFF_FFFF, 32'h0000_0AB0);
    run_op("R7", mk_bf(3'd2, 5'd0, 5'd0, 5'd7), 32'h1357_9BDF, 32'hFFFF_FFFF);
    run_op("R7", mk_bf(3'd2, 5'd31, 5'd31, 5'd1), 32'h0000_0000, 32'h8000_0000);
  endtask

  task automatic t_bf_extract;
    run_op("R8", mk_bf(3'd3, 5'd0, 5'd8, 5'd4), 32'h0000_0025, 32'hF0F0_1234);
    run_op("R8", mk_bf(3'd3, 5'd0, 5'd4, 5'd28), 32'hFFFF_FFE0, 32'h0000_000B);
    run_op("R9", mk_bf(3'd4, 5'd8, 5'd12, 5'd0), 32'h0000_0024, 32'h1234_5678);
    run_op("R9", mk_bf(3'd4, 5'd28, 5'd4, 5'd0), 32'h0000_001F, 32'hA000_0000);
  endtask

  task automatic t_read;
    run_op("R10", mk_imm(3'd5, 18'h3FFFC), 32'h0000_0100, 32'h0);
    run_op("R10", mk_imm(3'd5, 18'h00040), 32'h0000_0000, 32'h0);
  endtask

  task automatic t_invalid;
    run_op("R5", mk_rr(5'd2), 32'd9, 32'd1);
    run_op("R11", mk_imm(3'd6, 18'h00001), 32'h1111_1111, 32'h2222_2222);
    run_op("R11", mk_imm(3'd7, 18'h00001), 32'h1111_1111, 32'h2222_2222);
    run_op("R11", mk_rr(5'd5), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R11", mk_rr(5'd20), 32'h1, 32'h1);
    run_op("R11", mk_rr(5'd13), 32'h1, 32'h1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R2", "out_valid idle", 32'(out_valid), 0);
    chk("R2", "flags idle", {29'd0, carry_we, rd_req, invalid}, 0);
  endtask

  initial begin
    t_reset();
    t_add_carry();
    t_idle();
    t_sub_borrow();
    t_logic();
    t_addi();
    t_bf_replace();
    t_bf_extract();
    t_read();
    t_invalid();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule